// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a watchdog that software must service within a time window rather than just before a deadline. It is enabled, and from then on it repeats a cycle of two phases. First a closed phase runs for a programmed number of clock ticks. Then an open phase runs for a second programmed number of ticks. A refresh (kick) counts as legal only in the open phase, and a legal kick starts the cycle again from the closed phase. A kick that comes too early is a fault, and so is an open phase that ends with no kick. Each fault sets a sticky interrupt flag and sends a one-cycle reset request to the system.

All programming uses a simple 32-bit register bus with byte addresses. Writes take effect on the clock edge. Reads are combinational. The control register is guarded by a key bit. Software must set the key before each control write, and the key falls again once a control write has been accepted. The phase lengths can only be loaded while the watchdog is disabled. A closed-phase length of zero removes the closed phase, so kicks are legal at any time.

Top module: `win_watchdog`

## Requirements
- R1: After reset, `irq` and `rst_req` are 0. All registers read 0: key (0x00), control (0x04), closed length (0x0C) and open length (0x10). Offset 0x08 and unused offsets always read 0.
- R2: Bit 0 of the key register (0x00) can be written and read back. A write to control (0x04) is accepted only while this bit is 1, and otherwise it has no effect. Each accepted control write clears the key bit.
- R3: The closed length (0x0C) and open length (0x10) are full 32-bit values that read back as written. A write to either one is ignored while the watchdog is enabled.
- R4: The watchdog is enabled by an accepted control write with bit 0 = 1 while it is disabled. Call the edge that captures this write edge 0. With closed length C > 0 and open length L, the closed phase covers edges 1..C and the open phase covers edges C+1..C+L. If no kick arrives, the fault is registered on edge C+L, and `rst_req` is 1 for exactly the one cycle after it.
- R5: A kick is an accepted control write with bit 8 = 1 and bit 0 = 1 while the watchdog is enabled. A kick captured on an open-phase edge, including the last one, is legal and raises no fault. It restarts the closed phase, and the next timeout then falls C+L edges after the kick.
- R6: A kick captured on a closed-phase edge (1..C) is a fault. The fault is visible in the cycle after that edge, and the cycle restarts from the closed phase.
- R7: Control bit 16 is the sticky fault flag and drives `irq`. An accepted control write with bit 16 = 1 clears it. If a fault occurs on the same edge as the clear, the flag stays set. Every `rst_req` pulse comes with `irq` = 1.
- R8: Control bit 8 always reads 0. Control bit 0 reads back the stored enable.
- R9: An accepted control write with bit 0 = 0 disables the watchdog. While it is disabled, no fault occurs and `rst_req` stays 0.
- R10: With closed length 0, enabling goes straight to the open phase. Kicks on edges 1..L are legal, and with no kick the fault falls on edge L.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Bus write strobe, sampled on the rising edge |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Bus read strobe |
| rd_addr | input | ADDR_W | Byte address of the read |
| rd_data | output | 32 | Read data, combinational, 0 when `rd_en` is low |
| irq | output | 1 | Sticky fault flag |
| rst_req | output | 1 | One-cycle reset request on each fault |

## Verification
The assertions assume that at most one bus write arrives per cycle, with a stable address and data while the strobe is high. They also assume that a kick is always written together with the enable bit set. The bench drives every write on a falling edge and releases it one falling edge later, so each write is captured on exactly one rising edge. The bench places kicks at edge counts it has computed from the enable edge, so that the boundary edges of both phases are hit exactly. This includes a flag clear that lands on the timeout edge.

// File: rtl/win_watchdog.sv
module win_watchdog #(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  output logic              irq,
  output logic              rst_req
);

  localparam logic [ADDR_W-1:0] A_KEY   = ADDR_W'(5'h00);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(5'h04);
  localparam logic [ADDR_W-1:0] A_SHUT  = ADDR_W'(5'h0C);
  localparam logic [ADDR_W-1:0] A_OPEN  = ADDR_W'(5'h10);
  localparam int B_EN   = 0;
  localparam int B_KICK = 8;
  localparam int B_FLAG = 16;

  typedef enum logic [1:0] {PH_IDLE, PH_SHUT, PH_OPEN} phase_t;

  phase_t           phase_q;
  logic [CNT_W-1:0] cnt_q, shut_len_q, open_len_q;
  logic             key_q, en_q, flag_q, req_q;

  logic ctrl_ok, en_d, kick, start, last, bad, good, reload;

  assign ctrl_ok = wr_en && wr_addr == A_CTRL && key_q;
  assign en_d    = ctrl_ok ? wr_data[B_EN] : en_q;
  assign kick    = ctrl_ok && wr_data[B_KICK] && wr_data[B_EN] && en_q;
  assign start   = ctrl_ok && wr_data[B_EN] && !en_q;
  assign last    = cnt_q <= CNT_W'(1);
  assign bad     = en_q && en_d &&
                   ((kick && phase_q == PH_SHUT) ||
                    (!kick && phase_q == PH_OPEN && last));
  assign good    = kick && phase_q == PH_OPEN;
  assign reload  = start || bad || good;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q <= 1'b0;
    end else if (wr_en && wr_addr == A_KEY) begin
      key_q <= wr_data[0];
    end else if (ctrl_ok) begin
      key_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shut_len_q <= '0;
      open_len_q <= '0;
    end else if (wr_en && !en_q) begin
      if (wr_addr == A_SHUT) shut_len_q <= wr_data[CNT_W-1:0];
      if (wr_addr == A_OPEN) open_len_q <= wr_data[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      en_q <= en_d;
      if (!en_d) begin
        phase_q <= PH_IDLE;
        cnt_q   <= '0;
      end else if (reload) begin
        if (shut_len_q == '0) begin
          phase_q <= PH_OPEN;
          cnt_q   <= open_len_q;
        end else begin
          phase_q <= PH_SHUT;
          cnt_q   <= shut_len_q;
        end
      end else if (phase_q == PH_SHUT && last) begin
        phase_q <= PH_OPEN;
        cnt_q   <= open_len_q;
      end else begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      req_q <= bad;
      if (bad) flag_q <= 1'b1;
      else if (ctrl_ok && wr_data[B_FLAG]) flag_q <= 1'b0;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      case (rd_addr)
        A_KEY:  rd_data[0] = key_q;
        A_CTRL: begin
          rd_data[B_EN]   = en_q;
          rd_data[B_FLAG] = flag_q;
        end
        A_SHUT: rd_data[CNT_W-1:0] = shut_len_q;
        A_OPEN: rd_data[CNT_W-1:0] = open_len_q;
        default: rd_data = '0;
      endcase
    end
  end

  assign irq     = flag_q;
  assign rst_req = req_q;

  p_key_drops_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_CTRL && key_q) |=> !key_q);

  p_len_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> ($stable(shut_len_q) && $stable(open_len_q)));

  p_early_kick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && phase_q == PH_SHUT && wr_en && wr_addr == A_CTRL && key_q &&
     wr_data[B_EN] && wr_data[B_KICK]) |=> (rst_req && irq));

  p_req_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> irq);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> !rst_req);

  p_phase_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_IDLE) == !en_q);

endmodule

// File: tb/win_watchdog_tb.sv
module win_watchdog_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [4:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        irq, rst_req;
  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  win_watchdog u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq), .rst_req(rst_req));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [4:0] a, output logic [31:0] d);
    rd_en = 1'b1; rd_addr = a;
    #1 d = rd_data;
    rd_en = 1'b0;
  endtask

  task automatic ctrl_wr(input logic [31:0] d);
    bus_wr(5'h00, 32'h1);
    bus_wr(5'h04, d);
  endtask

  task automatic setup(input int c, input int l);
    ctrl_wr(32'h0001_0000);
    bus_wr(5'h0C, c);
    bus_wr(5'h10, l);
    ctrl_wr(32'h1);
  endtask

  task automatic wait_req(output int n);
    n = 0;
    for (int j = 1; j <= 40; j++) begin
      @(negedge clk);
      if (rst_req && n == 0) n = j;
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 irq", irq, 0);
    check("R1 rst_req", rst_req, 0);
    bus_rd(5'h04, d); check("R1 ctrl", d, 0);
    bus_rd(5'h0C, d); check("R1 closed len", d, 0);
    bus_rd(5'h08, d); check("R1 offset 8", d, 0);
  endtask

  task automatic t_key();
    logic [31:0] d;
    bus_wr(5'h04, 32'h1);
    bus_rd(5'h04, d); check("R2 locked write ignored", d, 0);
    bus_wr(5'h00, 32'h1);
    bus_rd(5'h00, d); check("R2 key readback", d, 1);
    bus_wr(5'h04, 32'h0);
    bus_rd(5'h00, d); check("R2 key self-clears", d, 0);
  endtask

  task automatic t_lengths();
    logic [31:0] d;
    bus_wr(5'h0C, 32'hDEAD_BEEF);
    bus_rd(5'h0C, d); check("R3 closed len readback", d, 32'hDEAD_BEEF);
    setup(4, 5);
    bus_wr(5'h0C, 32'd99);
    bus_rd(5'h0C, d); check("R3 write ignored while enabled", d, 4);
    bus_rd(5'h04, d); check("R8 ctrl reads enable", d, 1);
    ctrl_wr(32'h0);
  endtask

  task automatic t_timeout();
    int n;
    setup(4, 5);
    wait_req(n);
    check("R4 timeout edge", n, 9);
    check("R7 flag set", irq, 1);
    ctrl_wr(32'h0001_0000);
  endtask

  task automatic t_early_kick();
    int n;
    setup(4, 5);
    repeat (2) @(negedge clk);
    ctrl_wr(32'h101);
    check("R6 kick on last closed edge faults", rst_req, 1);
    check("R6 irq", irq, 1);
    @(negedge clk);
    check("R4 pulse is one cycle", rst_req, 0);
    ctrl_wr(32'h0001_0001);
    check("R7 W1C clears flag", irq, 0);
    ctrl_wr(32'h0);
  endtask

  task automatic t_legal_kicks();
    logic [31:0] d;
    int n;
    setup(4, 5);
    repeat (3) @(negedge clk);
    ctrl_wr(32'h101);
    check("R5 first open edge kick", rst_req, 0);
    bus_rd(5'h04, d); check("R8 kick reads 0", d, 1);
    repeat (7) @(negedge clk);
    ctrl_wr(32'h101);
    check("R5 last open edge kick", rst_req, 0);
    check("R5 no flag", irq, 0);
    wait_req(n);
    check("R5 timeout after kick", n, 9);
    ctrl_wr(32'h0001_0000);
  endtask

  task automatic t_clear_collide();
    setup(4, 5);
    repeat (7) @(negedge clk);
    ctrl_wr(32'h0001_0001);
    check("R7 set wins over clear", irq, 1);
    check("R7 req on collision", rst_req, 1);
    ctrl_wr(32'h0001_0000);
  endtask

  task automatic t_zero_closed();
    int n;
    setup(0, 5);
    ctrl_wr(32'h101);
    check("R10 early kick legal", rst_req, 0);
    check("R10 no flag", irq, 0);
    wait_req(n);
    check("R10 open-only timeout", n, 5);
    ctrl_wr(32'h0001_0000);
  endtask

  task automatic t_disable();
    int n;
    logic [31:0] d;
    setup(2, 2);
    ctrl_wr(32'h0);
    wait_req(n);
    check("R9 no request while disabled", n, 0);
    bus_rd(5'h04, d); check("R9 ctrl reads disabled", d, 0);
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_key();
    t_lengths();
    t_timeout();
    t_early_kick();
    t_legal_kicks();
    t_clear_collide();
    t_zero_closed();
    t_disable();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule